// File: doc/BRIEF.md
# Octant-Folded Sine/Cosine Generator

This block is a numerically controlled oscillator that delivers one signed sine sample and one signed cosine sample on every clock, both taken from the same phase. A phase accumulator advances by a tuning word on each enabled cycle. A phase-offset word is added to the accumulator value to form the sample phase. The sample phase is then split into three fields: the top three bits give the octant of the circle, the next bits address a small table, and the bits below those weight a straight-line interpolation between two neighbouring table entries.

The table covers only the first eighth of a turn (0 to pi/4). It stores sine and cosine values there, plus one extra entry at pi/4. The octant bits mirror the in-octant angle, swap the roles of the two lookups and negate each result, which rebuilds the whole circle from that small table. The table is computed during elaboration, so no memory file is needed. The design is small enough for distributed memory and has a fixed four-register pipeline.

Top module: `sincos_octant_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `sin_out`, `cos_out` and `out_valid` are all zero.
- R2: On each rising edge where `en` is 1, the accumulator becomes accumulator + `ftw` modulo 2^PHASE_W. When `en` is 0 the accumulator does not change.
- R3: `out_valid` rises exactly on the fourth rising edge, counting the edge at which `en` is sampled high. That output pair belongs to the phase formed at that first edge. When `en` is 0 at an edge, `out_valid` is 0 four edges later.
- R4: Table entry k, for k = 0 to 2^ADDR_W, holds S(k) = round(AMP*sin(k*pi/(4*2^ADDR_W))) and C(k) = round(AMP*cos(k*pi/(4*2^ADDR_W))), where AMP = 2^(OUT_W-1)-1. At an in-octant angle with a zero fraction in octant 0, the outputs are exactly S(k) and C(k).
- R5: The sample phase is P = accumulator (the value before this edge's addition) + `poff`, modulo 2^PHASE_W.
  - The octant is o = P[PHASE_W-1:PHASE_W-3].
  - The low field w is P[PHASE_W-4:0], bitwise inverted when o is odd.
  - The address a is the top ADDR_W bits of w, and the fraction f is the next FRAC_W bits of w.
- R6: The interpolated values are s = S(a) + floor((S(a+1)-S(a))*f / 2^FRAC_W) and c = C(a) + floor((C(a+1)-C(a))*f / 2^FRAC_W).
- R7: For octants 0 to 7 in order, the (sine, cosine) outputs are:
  - (s, c), (c, s), (c, -s), (s, -c)
  - (-s, -c), (-c, -s), (-c, s), (-s, c)
- R8: `poff` moves only the sample phase and never enters the accumulator. With `ftw` = 0, an offset of 0, 2^(PHASE_W-2), 2^(PHASE_W-1) or 3*2^(PHASE_W-2) gives (0, AMP), (AMP, 0), (0, -AMP) or (-AMP, 0) respectively.
- R9: Accumulator overflow wraps with no saturation or correction, so a tuning word above half scale produces a phase that runs backward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the accumulator and launch a sample |
| ftw | input | PHASE_W | Frequency tuning word added per enabled cycle |
| poff | input | PHASE_W | Phase offset added to the accumulator for the sample |
| sin_out | output | OUT_W | Signed sine sample |
| cos_out | output | OUT_W | Signed cosine sample |
| out_valid | output | 1 | Output pair is valid |

## Verification
Each input set applied before rising edge k yields its pair and its valid flag right after edge k+3. The bench's reference model therefore pushes one expected entry per edge into a queue that is pre-loaded with four idle entries. It pops exactly one entry at every falling edge, comparing the valid flag always and both samples whenever that entry is valid. The direct checks at the octant boundaries and at table points keep `ftw` at zero for several cycles before sampling, so the pipeline has settled on a single phase.

// File: rtl/sincos_oct_pkg.sv
// Package: shared constants and the elaboration-time table generator for the
// octant-folded sine/cosine generator. Assumes only standard real math.
package sincos_oct_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Rounded table value at step k of an eighth-turn split into 2**addr_w steps.
    function automatic int rom_entry(input int k, input int addr_w, input int amp,
                                     input bit want_cos);
        real ang;
        real v;
        ang = real'(k) * PI_R / (4.0 * real'(1 << addr_w));
        if (want_cos) v = real'(amp) * $cos(ang);
        else          v = real'(amp) * $sin(ang);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/sincos_phase_acc.sv
// Phase accumulator stage. Adds the tuning word on each enabled cycle and
// registers the sample phase (pre-add accumulator plus offset). Assumes
// wrap-around at 2**PHASE_W is the intended full-turn behaviour.
module sincos_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    input  logic [PHASE_W-1:0] poff,
    output logic [PHASE_W-1:0] acc,
    output logic [PHASE_W-1:0] phase,
    output logic               vld
);

    // Advance accumulator and capture sample phase when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            phase <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= en;
            if (en) begin
                acc   <= acc + ftw;
                phase <= acc + poff;
            end
        end
    end

endmodule

// File: rtl/sincos_oct_lookup.sv
// Octant decode and table read. Splits the phase into octant, address and
// fraction, mirrors the low field in odd octants, and reads the two adjacent
// sine and cosine entries. The table has 2**ADDR_W+1 entries built at
// elaboration. Assumes ADDR_W+FRAC_W <= PHASE_W-3.
module sincos_oct_lookup
    import sincos_oct_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 6,
    parameter int FRAC_W  = 8,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PHASE_W-1:0]      phase,
    input  logic                    vld_in,
    output logic signed [OUT_W-1:0] s_lo,
    output logic signed [OUT_W-1:0] s_hi,
    output logic signed [OUT_W-1:0] c_lo,
    output logic signed [OUT_W-1:0] c_hi,
    output logic [FRAC_W-1:0]       frac,
    output logic [2:0]              oct,
    output logic                    vld
);

    localparam int LOW_W = PHASE_W - 3;
    localparam int N     = 1 << ADDR_W;
    localparam int AMP   = (1 << (OUT_W - 1)) - 1;

    logic signed [OUT_W-1:0] sin_rom [0:N];
    logic signed [OUT_W-1:0] cos_rom [0:N];

    // One sine and one cosine entry per step, including the end point.
    for (genvar k = 0; k <= N; k++) begin : g_rom
        localparam int SV = rom_entry(k, ADDR_W, AMP, 1'b0);
        localparam int CV = rom_entry(k, ADDR_W, AMP, 1'b1);
        assign sin_rom[k] = OUT_W'(SV);
        assign cos_rom[k] = OUT_W'(CV);
    end

    logic [2:0]        oct_c;
    logic [LOW_W-1:0]  low_c;
    logic [ADDR_W:0]   a_lo;
    logic [ADDR_W:0]   a_hi;
    logic [FRAC_W-1:0] f_c;

    // Split phase; mirror the low field where the in-octant angle runs back.
    always_comb begin
        oct_c = phase[PHASE_W-1 -: 3];
        low_c = phase[LOW_W-1:0] ^ {LOW_W{oct_c[0]}};
        a_lo  = {1'b0, low_c[LOW_W-1 -: ADDR_W]};
        a_hi  = a_lo + 1'b1;
        f_c   = low_c[LOW_W-ADDR_W-1 -: FRAC_W];
    end

    // Register the four table reads and carry the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_lo <= '0;
            s_hi <= '0;
            c_lo <= '0;
            c_hi <= '0;
            frac <= '0;
            oct  <= '0;
            vld  <= 1'b0;
        end else begin
            s_lo <= sin_rom[a_lo];
            s_hi <= sin_rom[a_hi];
            c_lo <= cos_rom[a_lo];
            c_hi <= cos_rom[a_hi];
            frac <= f_c;
            oct  <= oct_c;
            vld  <= vld_in;
        end
    end

endmodule

// File: rtl/sincos_interp.sv
// One linear interpolation lane: y = lo + floor((hi-lo)*frac / 2**FRAC_W),
// registered. Assumes the result lies between lo and hi and so fits OUT_W.
module sincos_interp #(
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OUT_W-1:0] lo,
    input  logic signed [OUT_W-1:0] hi,
    input  logic [FRAC_W-1:0]       frac,
    output logic signed [OUT_W-1:0] y
);

    localparam int XW = OUT_W + FRAC_W + 2;

    logic signed [XW-1:0] lo_x;
    logic signed [XW-1:0] hi_x;
    logic signed [XW-1:0] fr_x;
    logic signed [XW-1:0] prod;
    logic signed [XW-1:0] sum;

    // Widen, scale the slope by the fraction and add the base value.
    always_comb begin
        lo_x = XW'(lo);
        hi_x = XW'(hi);
        fr_x = $signed(XW'({1'b0, frac}));
        prod = (hi_x - lo_x) * fr_x;
        sum  = lo_x + (prod >>> FRAC_W);
    end

    // Register the interpolated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= sum[OUT_W-1:0];
    end

endmodule

// File: rtl/sincos_oct_fold.sv
// Octant fold: swaps the two interpolated values where the octant maps the
// first-eighth angle onto the other axis, then applies each output's sign.
// Assumes inputs are non-negative, so negation cannot overflow.
module sincos_oct_fold #(
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OUT_W-1:0] s_in,
    input  logic signed [OUT_W-1:0] c_in,
    input  logic [2:0]              oct,
    input  logic                    vld_in,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out,
    output logic                    out_valid
);

    logic                    swap;
    logic                    neg_s;
    logic                    neg_c;
    logic signed [OUT_W-1:0] sel_s;
    logic signed [OUT_W-1:0] sel_c;

    // Choose roles and signs from the octant number.
    always_comb begin
        swap  = oct[1] ^ oct[0];
        neg_s = oct[2];
        neg_c = oct[2] ^ oct[1];
        sel_s = swap ? c_in : s_in;
        sel_c = swap ? s_in : c_in;
    end

    // Register the full-circle output pair and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_out   <= '0;
            cos_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            sin_out   <= neg_s ? -sel_s : sel_s;
            cos_out   <= neg_c ? -sel_c : sel_c;
            out_valid <= vld_in;
        end
    end

endmodule

// File: rtl/sincos_octant_gen.sv
// Top: phase accumulator -> octant table read -> interpolation -> fold.
// Four registers from enable to output. Assumes ADDR_W+FRAC_W <= PHASE_W-3.
module sincos_octant_gen #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 6,
    parameter int FRAC_W  = 8,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [PHASE_W-1:0]      ftw,
    input  logic [PHASE_W-1:0]      poff,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out,
    output logic                    out_valid
);

    logic [PHASE_W-1:0]      acc;
    logic [PHASE_W-1:0]      phase;
    logic                    v1;
    logic signed [OUT_W-1:0] s_lo;
    logic signed [OUT_W-1:0] s_hi;
    logic signed [OUT_W-1:0] c_lo;
    logic signed [OUT_W-1:0] c_hi;
    logic [FRAC_W-1:0]       frac;
    logic [2:0]              oct2;
    logic                    v2;
    logic signed [OUT_W-1:0] lane_y [2];
    logic [2:0]              oct3;
    logic                    v3;

    sincos_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(en), .ftw(ftw), .poff(poff),
        .acc(acc), .phase(phase), .vld(v1)
    );

    sincos_oct_lookup #(
        .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .vld_in(v1),
        .s_lo(s_lo), .s_hi(s_hi), .c_lo(c_lo), .c_hi(c_hi),
        .frac(frac), .oct(oct2), .vld(v2)
    );

    // Lane 0 interpolates sine entries, lane 1 cosine entries.
    for (genvar i = 0; i < 2; i++) begin : g_lane
        sincos_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_int (
            .clk(clk), .rst_n(rst_n),
            .lo(i == 0 ? s_lo : c_lo),
            .hi(i == 0 ? s_hi : c_hi),
            .frac(frac),
            .y(lane_y[i])
        );
    end

    // Delay octant and valid alongside the interpolation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct3 <= '0;
            v3   <= 1'b0;
        end else begin
            oct3 <= oct2;
            v3   <= v2;
        end
    end

    sincos_oct_fold #(.OUT_W(OUT_W)) u_fold (
        .clk(clk), .rst_n(rst_n), .s_in(lane_y[0]), .c_in(lane_y[1]),
        .oct(oct3), .vld_in(v3),
        .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
    );

endmodule

// File: rtl/sincos_octant_chk.sv
// Checker for sincos_octant_gen: accumulator stepping, valid latency and
// output range. Bound to every instance of the top module.
module sincos_octant_chk #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [PHASE_W-1:0]      ftw,
    input logic [PHASE_W-1:0]      acc,
    input logic signed [OUT_W-1:0] sin_out,
    input logic signed [OUT_W-1:0] cos_out,
    input logic                    out_valid
);

    localparam int AMP = (1 << (OUT_W - 1)) - 1;

    logic [2:0] since_rst;

    // Count edges out of reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 4) since_rst <= since_rst + 1'b1;
    end

    // R2: enabled edge adds the tuning word
    a_r2_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> acc == $past(acc) + $past(ftw));

    // R2: disabled edge leaves the accumulator alone
    a_r2_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc));

    // R3: valid follows enable by four edges
    a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 4) |-> out_valid == $past(en, 4));

    // R7: folded outputs stay within the table amplitude
    a_r7_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sin_out >= -AMP && sin_out <= AMP &&
                       cos_out >= -AMP && cos_out <= AMP));

endmodule

bind sincos_octant_gen sincos_octant_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .ftw(ftw), .acc(acc),
    .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
);

// File: tb/sincos_octant_gen_test.sv
// Bench: behavioural reference model with a per-edge expectation queue.
module sincos_octant_gen_test;

    localparam real PI_R = 3.14159265358979323846;
    localparam int  AMP  = 32767;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic [31:0]        ftw = '0;
    logic [31:0]        poff = '0;
    logic signed [15:0] sin_out;
    logic signed [15:0] cos_out;
    logic               out_valid;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    logic [31:0] m_acc = '0;
    int q_v[$];
    int q_s[$];
    int q_c[$];
    bit oct_seen[8];

    sincos_octant_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ftw(ftw), .poff(poff),
        .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
    );

    always #2 clk = ~clk;

    function automatic int tab(input int k, input bit want_cos);
        real ang;
        ang = real'(k) * PI_R / (4.0 * 64.0);
        if (want_cos) return $rtoi(real'(AMP) * $cos(ang) + 0.5);
        return $rtoi(real'(AMP) * $sin(ang) + 0.5);
    endfunction

    task automatic model(input logic [31:0] ph, output int so, output int co);
        logic [2:0]  o;
        logic [28:0] w;
        int a, f, s, c;
        o = ph[31:29];
        w = ph[28:0];
        if (o[0]) w = ~w;
        a = int'(w[28:23]);
        f = int'(w[22:15]);
        s = tab(a, 0) + (((tab(a + 1, 0) - tab(a, 0)) * f) >>> 8);
        c = tab(a, 1) + (((tab(a + 1, 1) - tab(a, 1)) * f) >>> 8);
        case (o)
            3'd0: begin so = s;  co = c;  end
            3'd1: begin so = c;  co = s;  end
            3'd2: begin so = c;  co = -s; end
            3'd3: begin so = s;  co = -c; end
            3'd4: begin so = -s; co = -c; end
            3'd5: begin so = -c; co = -s; end
            3'd6: begin so = -c; co = s;  end
            default: begin so = -s; co = c; end
        endcase
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: compare the pair due now, then drive and predict the next.
    task automatic cycle(input logic e, input logic [31:0] f, input logic [31:0] p);
        int ev, es, ec, so, co;
        @(negedge clk);
        ev = q_v.pop_front();
        es = q_s.pop_front();
        ec = q_c.pop_front();
        check(tag, "valid", int'(out_valid), ev);
        if (ev != 0) begin
            check(tag, "sin", int'(sin_out), es);
            check(tag, "cos", int'(cos_out), ec);
            oct_seen[q_oct.pop_front()] = 1'b1;
        end
        en   = e;
        ftw  = f;
        poff = p;
        if (e) begin
            model(m_acc + p, so, co);
            q_v.push_back(1);
            q_s.push_back(so);
            q_c.push_back(co);
            q_oct.push_back(int'(p3(m_acc + p)));
            m_acc = m_acc + f;
        end else begin
            q_v.push_back(0);
            q_s.push_back(0);
            q_c.push_back(0);
        end
    endtask

    int q_oct[$];

    function automatic logic [2:0] p3(input logic [31:0] ph);
        return ph[31:29];
    endfunction

    task automatic expect_now(input string req, input int s, input int c);
        check(req, "sin direct", int'(sin_out), s);
        check(req, "cos direct", int'(cos_out), c);
    endtask

    task automatic hold_phase(input logic [31:0] p);
        for (int i = 0; i < 6; i++) cycle(1'b1, 32'd0, p);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", "valid in reset", int'(out_valid), 0);
        check("R1", "sin in reset", int'(sin_out), 0);
        check("R1", "cos in reset", int'(cos_out), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            q_v.push_back(0);
            q_s.push_back(0);
            q_c.push_back(0);
        end
        @(negedge clk);
        check("R1", "valid after release", int'(out_valid), 0);
        check("R1", "sin after release", int'(sin_out), 0);
        void'(q_v.pop_front()); void'(q_s.pop_front()); void'(q_c.pop_front());
        q_v.push_back(0); q_s.push_back(0); q_c.push_back(0);

        // R8: quadrant boundary offsets with a frozen phase
        tag = "R8";
        hold_phase(32'h0000_0000); expect_now("R8", 0, AMP);
        hold_phase(32'h4000_0000); expect_now("R8", AMP, 0);
        hold_phase(32'h8000_0000); expect_now("R8", 0, -AMP);
        hold_phase(32'hC000_0000); expect_now("R8", -AMP, 0);

        // R4: exact table points in octant 0
        tag = "R4";
        hold_phase(32'd32 << 23); expect_now("R4", tab(32, 0), tab(32, 1));
        hold_phase(32'd5 << 23);  expect_now("R4", tab(5, 0), tab(5, 1));

        // R3: single enable pulse surrounded by idle cycles
        tag = "R3";
        for (int i = 0; i < 6; i++) cycle(i == 1, 32'h0100_0000, 32'h1234_5678);

        // R5: slow sweep through a mirrored octant
        tag = "R5";
        for (int i = 0; i < 600; i++) cycle(1'b1, 32'h0001_3000, 32'h2000_0000);

        // R6: fine steps across table intervals in octant 0
        tag = "R6";
        m_acc = m_acc;
        for (int i = 0; i < 600; i++) cycle(1'b1, 32'h0000_9100, 32'h0000_0000);

        // R7: fast sweep over the whole circle
        tag = "R7";
        for (int i = 0; i < 8; i++) oct_seen[i] = 1'b0;
        for (int i = 0; i < 800; i++) cycle(1'b1, 32'h0123_4567, 32'h0000_0000);
        for (int i = 0; i < 8; i++) check("R7", "octant reached", int'(oct_seen[i]), 1);

        // R2: enable gaps must freeze the accumulator
        tag = "R2";
        for (int i = 0; i < 600; i++) cycle(i % 3 != 0, 32'h0777_0000, 32'h0000_0000);

        // R9: tuning word above half scale, phase runs backward through wrap
        tag = "R9";
        for (int i = 0; i < 400; i++) cycle(1'b1, 32'hF0F0_0001, 32'h0000_0000);

        // R8: offset changing every cycle alongside a running accumulator
        tag = "R8";
        for (int i = 0; i < 400; i++) cycle(1'b1, 32'h0300_0000, 32'h0B00_0000 * i);

        tag = "R3";
        for (int i = 0; i < 6; i++) cycle(1'b0, 32'd0, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule